// File: doc/BRIEF.md
# Machine Clock Mode Controller

This block decides which source drives a microcontroller's machine clock: the main oscillator, the PLL, or the low-speed subclock. Software writes a 16-bit select register. Its two select bits are active-low. A request for the subclock overrides a request for the PLL. When neither is requested, the main oscillator is used. The controller then moves its mode state machine to the requested source. Each kind of switch waits in its own way before the new mode takes effect. Until the switch completes, the previous mode stays active and a busy flag is raised.

There are two waiting rules. Switches into the PLL from the main oscillator wait a fixed power-of-two number of main-clock cycles. Switches out of subclock mode wait a power-of-two count chosen by a 2-bit wait-select field. Switches into subclock mode complete on the next subclock edge event. Switches that start a counted wait also emit a one-cycle pulse that clears the timebase timer. The PLL multiplier field can only be changed while the PLL is deselected. The field is joined with a third multiplier bit held outside this block to form the multiplier code. The glitch-free multiplexer itself lies outside the block and is driven from the mode output.

Top module: `clk_mode_ctl`

## Requirements
- R1: After reset, `rd_data` reads 16'h0C00. That is: multiplier field [9:8]=0, PLL-select-n [10]=1, subclock-select-n [11]=1, wait-select [13:12]=0 and mode [15:14]=0 (main). `busy` and `tb_clr` are 0.
- R2: The target mode is subclock (mode code 2) whenever bit 11 is 0. Otherwise it is PLL (code 1) when bit 10 is 0, and main (code 0) when both bits are 1. The mode never takes code 3.
- R3: A write updates the multiplier field [9:8] only if bit 10 of the register was 1 before that write. Otherwise the field keeps its old value.
- R4: A switch from main to PLL completes 2^FIX_EXP + 1 cycles after the write edge. The mode holds its old value until then.
- R5: A switch from subclock to PLL or to main completes 2^E + 1 cycles after the write edge. E is WS_EXP0..WS_EXP3 for wait-select codes 0..3.
- R6: `tb_clr` is high for exactly the one cycle after the write edge when a counted switch starts (main to PLL, subclock to PLL, subclock to main). It stays low for every other write.
- R7: A switch into subclock mode (from main or from PLL) completes at the first clock edge, after the start cycle, at which `sub_edge` is high.
- R8: A switch from PLL to main takes effect one cycle after the write edge, with no wait.
- R9: `busy` is high from the start of a waited switch until the mode updates. The current mode is visible both on `mode` and in `rd_data[15:14]`.
- R10: `mul_code` equals {`mul_hi`, register bits [9:8]}.
- R11: With HAS_SUB = 0, bit 11 always reads 1, writes to it are ignored, and the mode never becomes subclock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register contents plus current mode in [15:14] |
| mul_hi | input | 1 | Third multiplier bit from a separate register |
| sub_edge | input | 1 | One-cycle pulse marking a subclock edge, already synchronized to `clk` |
| mode | output | 2 | Active clock mode: 0 main, 1 PLL, 2 subclock |
| mul_code | output | 3 | Effective PLL multiplier code |
| tb_clr | output | 1 | One-cycle timebase timer clear pulse |
| busy | output | 1 | A mode switch is in progress |

## Verification
The hardest situation to reach is a write to the multiplier field while the PLL stays selected. That case needs the register to be in PLL mode with its wait fully elapsed, and then a write that keeps bit 10 low. The stimulus walks the three-step change sequence in directed form. After that, it issues seeded random writes. Each random write is applied only once the previous switch has completed, so the bench model knows the old mode. For subclock entries the bench also holds `sub_edge` low for a random number of cycles, which proves the switch waits for the edge.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
   typedef enum logic [1:0] {
      MODE_MAIN = 2'd0,
      MODE_PLL  = 2'd1,
      MODE_SUB  = 2'd2
   } mode_e;

   typedef enum logic [1:0] {
      WK_NONE  = 2'd0,
      WK_COUNT = 2'd1,
      WK_SYNC  = 2'd2
   } wait_e;

   localparam int REG_W    = 16;
   localparam int EXP_W    = 5;
   localparam int B_MUL_LO = 8;
   localparam int B_PLL_N  = 10;
   localparam int B_SUB_N  = 11;
   localparam int B_WS_LO  = 12;
endpackage

// File: rtl/clk_sel_reg.sv
module clk_sel_reg
   import clk_mode_pkg::*;
#(
   parameter bit HAS_SUB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [1:0]       mul,
   output logic             pll_n,
   output logic             sub_n,
   output logic [1:0]       ws
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul   <= 2'b00;
         pll_n <= 1'b1;
         ws    <= 2'b00;
      end else if (wr_en) begin
         if (pll_n) mul <= wr_data[B_MUL_LO +: 2];
         pll_n <= wr_data[B_PLL_N];
         ws    <= wr_data[B_WS_LO +: 2];
      end
   end

   generate
      if (HAS_SUB) begin : g_sub
         logic sub_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sub_q <= 1'b1;
            else if (wr_en) sub_q <= wr_data[B_SUB_N];
         end
         assign sub_n = sub_q;
      end else begin : g_nosub
         assign sub_n = 1'b1;
      end
   endgenerate

   AST_MUL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_n |=> mul == $past(mul)); // R3
endmodule

// File: rtl/clk_wait_timer.sv
module clk_wait_timer
   import clk_mode_pkg::*;
#(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [EXP_W-1:0] len_exp,
   output logic             done
);
   logic [CNT_W-1:0] cnt;
   logic             run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= ({{(CNT_W-1){1'b0}}, 1'b1} << len_exp) - 1'b1;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign done = run && (cnt == '0);

   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> !done); // R5
endmodule

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
   import clk_mode_pkg::*;
#(
   parameter int FIX_EXP = 14,
   parameter int WS_EXP0 = 10,
   parameter int WS_EXP1 = 13,
   parameter int WS_EXP2 = 15,
   parameter int WS_EXP3 = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pll_n,
   input  logic             sub_n,
   input  logic [1:0]       ws,
   input  logic             sub_edge,
   input  logic             done,
   output logic             load,
   output logic [EXP_W-1:0] len_exp,
   output mode_e            mode,
   output logic             busy,
   output logic             tb_clr
);
   localparam int unsigned WS_TAB [4] = '{WS_EXP0, WS_EXP1, WS_EXP2, WS_EXP3};

   mode_e target, dest_q;
   wait_e kind, kind_q;
   logic  clr, start;

   always_comb begin
      if (!sub_n)      target = MODE_SUB;
      else if (!pll_n) target = MODE_PLL;
      else             target = MODE_MAIN;
   end

   always_comb begin
      kind    = WK_NONE;
      clr     = 1'b0;
      len_exp = EXP_W'(FIX_EXP);
      unique case (mode)
         MODE_MAIN: begin
            if (target == MODE_PLL) begin
               kind = WK_COUNT;
               clr  = 1'b1;
            end else if (target == MODE_SUB) begin
               kind = WK_SYNC;
            end
         end
         MODE_PLL: begin
            if (target == MODE_SUB) kind = WK_SYNC;
         end
         default: begin
            kind    = WK_COUNT;
            clr     = 1'b1;
            len_exp = EXP_W'(WS_TAB[ws]);
         end
      endcase
   end

   assign start = !busy && (target != mode);
   assign load  = start && (kind == WK_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= MODE_MAIN;
         dest_q <= MODE_MAIN;
         kind_q <= WK_NONE;
         busy   <= 1'b0;
         tb_clr <= 1'b0;
      end else begin
         tb_clr <= start && clr;
         if (start) begin
            if (kind == WK_NONE) begin
               mode <= target;
            end else begin
               busy   <= 1'b1;
               dest_q <= target;
               kind_q <= kind;
            end
         end else if (busy) begin
            if ((kind_q == WK_COUNT && done) || (kind_q == WK_SYNC && sub_edge)) begin
               mode <= dest_q;
               busy <= 1'b0;
            end
         end
      end
   end

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11); // R2
   AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q == WK_COUNT && !done) |=> $stable(mode)); // R4
   AST_SUB_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SUB && $past(mode) != MODE_SUB) |-> $past(sub_edge)); // R7
   AST_TBCLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      tb_clr |=> !tb_clr); // R6
endmodule

// File: rtl/clk_mode_ctl.sv
module clk_mode_ctl
   import clk_mode_pkg::*;
#(
   parameter bit HAS_SUB = 1'b1,
   parameter int FIX_EXP = 14,
   parameter int WS_EXP0 = 10,
   parameter int WS_EXP1 = 13,
   parameter int WS_EXP2 = 15,
   parameter int WS_EXP3 = 17
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   input  logic        mul_hi,
   input  logic        sub_edge,
   output logic [1:0]  mode,
   output logic [2:0]  mul_code,
   output logic        tb_clr,
   output logic        busy
);
   localparam int MAX_A   = (FIX_EXP > WS_EXP0) ? FIX_EXP : WS_EXP0;
   localparam int MAX_B   = (WS_EXP1 > WS_EXP2) ? WS_EXP1 : WS_EXP2;
   localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_EXP = (MAX_C > WS_EXP3) ? MAX_C : WS_EXP3;
   localparam int CNT_W   = MAX_EXP + 1;

   generate
      if (FIX_EXP < 1 || MAX_EXP > 30) begin : g_bad_exp
         $error("clk_mode_ctl: wait exponents must lie in 1..30");
      end
      if (WS_EXP0 < 1 || WS_EXP1 < 1 || WS_EXP2 < 1 || WS_EXP3 < 1) begin : g_bad_ws
         $error("clk_mode_ctl: wait-select exponents must be at least 1");
      end
   endgenerate

   logic [1:0]       mul, ws;
   logic             pll_n, sub_n, load, done;
   logic [EXP_W-1:0] len_exp;
   mode_e            mode_s;

   clk_sel_reg #(.HAS_SUB(HAS_SUB)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .mul(mul), .pll_n(pll_n), .sub_n(sub_n), .ws(ws)
   );

   clk_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .len_exp(len_exp), .done(done)
   );

   clk_mode_fsm #(
      .FIX_EXP(FIX_EXP), .WS_EXP0(WS_EXP0), .WS_EXP1(WS_EXP1),
      .WS_EXP2(WS_EXP2), .WS_EXP3(WS_EXP3)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .pll_n(pll_n), .sub_n(sub_n), .ws(ws),
      .sub_edge(sub_edge), .done(done), .load(load), .len_exp(len_exp),
      .mode(mode_s), .busy(busy), .tb_clr(tb_clr)
   );

   assign mode     = mode_s;
   assign mul_code = {mul_hi, mul};
   assign rd_data  = {mode_s, ws, sub_n, pll_n, mul, 8'h00};

   AST_BUSY_ENDS_IN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy)) |-> mode != $past(mode)); // R9
endmodule

// File: tb/clk_mode_ctl_test.sv
module clk_mode_ctl_test;
   localparam int FIX = 4;
   localparam int W0 = 3, W1 = 5, W2 = 6, W3 = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        mul_hi = 1'b0;
   logic        sub_edge = 1'b0;
   logic [15:0] rd_data, ns_rd;
   logic [1:0]  mode, ns_mode;
   logic [2:0]  mul_code, ns_mul;
   logic        tb_clr, busy, ns_clr, ns_busy;

   int total = 0;
   int bad = 0;
   bit ended = 1'b0;

   logic [1:0] m_mul = 2'b00, m_ws = 2'b00, m_mode = 2'd0;
   logic       m_pll_n = 1'b1, m_sub_n = 1'b1;

   always #5 clk = ~clk;

   clk_mode_ctl #(.FIX_EXP(FIX), .WS_EXP0(W0), .WS_EXP1(W1), .WS_EXP2(W2), .WS_EXP3(W3)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .mul_hi(mul_hi), .sub_edge(sub_edge), .mode(mode), .mul_code(mul_code),
      .tb_clr(tb_clr), .busy(busy)
   );

   clk_mode_ctl #(.HAS_SUB(1'b0), .FIX_EXP(FIX), .WS_EXP0(W0), .WS_EXP1(W1), .WS_EXP2(W2), .WS_EXP3(W3)) uut_ns (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(ns_rd),
      .mul_hi(mul_hi), .sub_edge(sub_edge), .mode(ns_mode), .mul_code(ns_mul),
      .tb_clr(ns_clr), .busy(ns_busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] target_of(input logic pn, input logic sn);
      if (!sn)      return 2'd2;
      else if (!pn) return 2'd1;
      else          return 2'd0;
   endfunction

   function automatic int ws_exp(input logic [1:0] w);
      case (w)
         2'd0: return W0;
         2'd1: return W1;
         2'd2: return W2;
         default: return W3;
      endcase
   endfunction

   // 0 none, 1 immediate, 2 counted, 3 sync
   function automatic int kind_of(input logic [1:0] o, input logic [1:0] t);
      if (o == t) return 0;
      if (t == 2'd2) return 3;
      if (o == 2'd1) return 1;
      return 2;
   endfunction

   task automatic expect_switch(input logic [1:0] o, input logic [1:0] t, input logic [1:0] w);
      int k, n;
      k = kind_of(o, t);
      if (k == 0) begin
         @(negedge clk);
         chk("R6 no clear without switch", {31'd0, tb_clr}, 32'd0);
         chk("R2 mode unchanged", {30'd0, mode}, {30'd0, o});
      end else if (k == 1) begin
         @(negedge clk);
         chk("R8 immediate pll->main", {30'd0, mode}, {30'd0, t});
         chk("R6 no clear pll->main", {31'd0, tb_clr}, 32'd0);
      end else if (k == 2) begin
         n = (o == 2'd0) ? (1 << FIX) : (1 << ws_exp(w));
         @(negedge clk);
         chk("R9 busy after start", {31'd0, busy}, 32'd1);
         chk("R6 clear pulse", {31'd0, tb_clr}, 32'd1);
         repeat (n - 1) @(negedge clk);
         chk((o == 2'd0) ? "R4 hold before end" : "R5 hold before end", {30'd0, mode}, {30'd0, o});
         @(negedge clk);
         chk((o == 2'd0) ? "R4 switch done" : "R5 switch done", {30'd0, mode}, {30'd0, t});
         chk("R9 busy cleared", {31'd0, busy}, 32'd0);
      end else begin
         @(negedge clk);
         chk("R6 no clear for sub entry", {31'd0, tb_clr}, 32'd0);
         repeat ($urandom_range(0, 5)) @(negedge clk);
         chk("R7 waits for sub edge", {30'd0, mode}, {30'd0, o});
         sub_edge = 1'b1;
         @(negedge clk);
         sub_edge = 1'b0;
         chk("R7 switch on sub edge", {30'd0, mode}, {30'd0, t});
      end
   endtask

   task automatic write_and_check(input logic [15:0] d);
      logic [1:0] o, t;
      o = m_mode;
      if (m_pll_n) m_mul = d[9:8];
      m_pll_n = d[10];
      m_sub_n = d[11];
      m_ws    = d[13:12];
      t = target_of(m_pll_n, m_sub_n);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      expect_switch(o, t, m_ws);
      m_mode = t;
      chk("R3 R9 register readback", {16'd0, rd_data}, {16'd0, m_mode, m_ws, m_sub_n, m_pll_n, m_mul, 8'h00});
      chk("R10 multiplier code", {29'd0, mul_code}, {29'd0, mul_hi, m_mul});
      chk("R11 sub bit fixed", {31'd0, ns_rd[11]}, 32'd1);
      chk("R11 never sub", {31'd0, (ns_mode == 2'd2)}, 32'd0);
      if (!ns_busy && ns_mode != 2'd1) begin
         repeat (2) @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4117));
      repeat (3) @(negedge clk);
      chk("R1 reset readback", {16'd0, rd_data}, 32'h0C00);
      chk("R1 reset busy", {31'd0, busy}, 32'd0);
      chk("R1 reset clear", {31'd0, tb_clr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode after release", {30'd0, mode}, 32'd0);

      write_and_check(16'h0F00);   // mul=3, stay main
      write_and_check(16'h0900);   // main->PLL, mul=1
      write_and_check(16'h0A00);   // R3 blocked while PLL selected
      write_and_check(16'h0D00);   // PLL->main, mul still blocked
      write_and_check(16'h0E00);   // R3 mul=2 now allowed
      write_and_check(16'h0A00);   // main->PLL
      mul_hi = 1'b1;
      @(negedge clk);
      chk("R10 upper bit", {29'd0, mul_code}, {29'd0, 1'b1, m_mul});
      write_and_check(16'h0000);   // R2 both low: PLL->sub
      write_and_check(16'h2C00);   // sub->main, ws=2
      write_and_check(16'h0300);   // main->sub
      write_and_check(16'h3B00);   // sub->PLL, ws=3
      mul_hi = 1'b0;

      for (int i = 0; i < 40; i++) begin
         write_and_check(16'($urandom()));
      end

      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule